// File: doc/BRIEF.md
# External Interrupt Trigger and Flag Controller

This block owns the external-interrupt fields of an 8-bit control byte for a small set of active-low interrupt pins (two by default). Each pin first passes through its own synchronizer. Software then chooses, one source at a time, between two trigger kinds. In low-level mode the request simply mirrors the pin. In falling-edge mode a sticky flag captures each high-to-low transition and holds the request until it is released.

The flag can be released in two ways. The interrupt controller pulses a per-source acknowledge when it services the request, or software writes the byte. The upper half of the byte belongs to timer logic elsewhere. Here it reads as zero and writes to it are dropped.

Each source runs a three-state machine. `ST_LEVEL` is low-level triggering. `ST_ARMED` is edge mode with the flag clear. `ST_PEND` is edge mode with the flag set. The transitions are as follows:
- **to_edge**: LEVEL→ARMED, or LEVEL→PEND if the same write also sets the flag.
- **to_level**: ARMED or PEND→LEVEL when a write clears the type bit.
- **catch**: ARMED→PEND on a detected falling edge or a software write of 1 to the flag.
- **release**: PEND→ARMED on acknowledge or a software write of 0 to the flag.
- **hold**: PEND→PEND when an edge arrives together with a release.

Top module: `ext_irq_ctl`

## Requirements
- R1: After reset the control byte reads 00h and no request is asserted while the pins idle high.
- R2: Source 0 has its type bit at position 0 and its flag at position 1. Source 1 has its type bit at position 2 and its flag at position 3. Bits 7:4 always read 0 and ignore writes.
- R3: With type bit 0 (low-level), the request equals the inverted pin after two synchronizer clocks, and the flag bit reads that same request value.
- R4: In low-level mode, acknowledge latches nothing: the request stays up while the pin is low and drops once the pin is seen high.
- R5: With type bit 1 (falling-edge), a pin seen high in one synchronized sample and low in the next sets the flag. Request and flag appear three clocks after the pin falls.
- R6: In edge mode the flag stays set after the pin returns high, and a rising edge does not set it.
- R7: In edge mode, an acknowledge pulse clears the flag and the request on the next clock.
- R8: A write with flag bit 0 clears the flag, and a write with flag bit 1 sets it.
- R9: When a falling edge is detected in the same cycle as an acknowledge, the flag remains set.
- R10: Writing the type bit to 0 discards a pending flag. A later return to edge mode starts with the flag clear.
- R11: Sources are independent: an edge, acknowledge or write on one source leaves the other source's request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | NUM_SRC | Asynchronous active-low interrupt pins |
| irq_ack | input | NUM_SRC | One-cycle service acknowledge per source |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | REG_W | Control byte write data |
| ctl_rdata | output | REG_W | Control byte read data |
| irq_req | output | NUM_SRC | Interrupt request per source |

## Verification
The bench builds the block with its defaults: two sources, an 8-bit byte and a two-stage synchronizer. With these values the exact pin-to-request latencies (two clocks for level, three for edge) can be pinned to fixed cycles, and two sources are enough to show that one source's activity never disturbs the other. The reference model tracks the synchronizer pipeline, previous sample, type and flag for each source, and it is compared against the request and readback on every clock. Around the model comparison, directed sequences place an edge on the same clock as an acknowledge and switch modes while a flag is pending.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        ST_LEVEL = 2'd0,
        ST_ARMED = 2'd1,
        ST_PEND  = 2'd2
    } chan_state_e;

    // Per-source field layout inside the control byte
    localparam int FIELD_W  = 2;
    localparam int TYPE_OFS = 0;
    localparam int FLAG_OFS = 1;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int   WIDTH     = 2,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= {WIDTH{RESET_VAL}};
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,      // synchronized, active low
    input  logic wr_en,
    input  logic wr_type,
    input  logic wr_flag,
    input  logic ack,
    output logic req,
    output logic type_rd,
    output logic flag_rd
);

    chan_state_e state_q, state_d;
    logic        pin_prev_q;
    logic        fall;

    // Previous synchronized sample for falling-edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev_q <= 1'b1;
        else        pin_prev_q <= pin_s;
    end

    assign fall = pin_prev_q & ~pin_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEVEL;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEVEL: begin
                if (wr_en && wr_type)
                    state_d = wr_flag ? ST_PEND : ST_ARMED;      // to_edge
            end
            ST_ARMED: begin
                if (wr_en && !wr_type)  state_d = ST_LEVEL;      // to_level
                else if (fall)          state_d = ST_PEND;       // catch (edge)
                else if (wr_en && wr_flag) state_d = ST_PEND;    // catch (software)
            end
            ST_PEND: begin
                if (wr_en && !wr_type)  state_d = ST_LEVEL;      // to_level
                else if (fall)          state_d = ST_PEND;       // hold
                else if (wr_en)         state_d = wr_flag ? ST_PEND : ST_ARMED;
                else if (ack)           state_d = ST_ARMED;      // release
            end
            default:                    state_d = ST_LEVEL;
        endcase
    end

    // Output logic
    always_comb begin
        req     = 1'b0;
        type_rd = 1'b0;
        flag_rd = 1'b0;
        unique case (state_q)
            ST_LEVEL: begin
                req     = ~pin_s;
                flag_rd = ~pin_s;
            end
            ST_ARMED: begin
                type_rd = 1'b1;
            end
            ST_PEND: begin
                req     = 1'b1;
                type_rd = 1'b1;
                flag_rd = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: an edge seen in edge mode with no mode change pends the request
    p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LEVEL && fall && !(wr_en && !wr_type)) |=> req);

    // R9: edge together with acknowledge keeps the flag
    p_edge_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && ack && fall && !wr_en) |=> (state_q == ST_PEND));

    // R7: acknowledge alone releases a pending flag
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && ack && !fall && !wr_en) |=> !flag_rd);

    // R6: with no edge, acknowledge or write, a pending flag persists
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !ack && !wr_en) |=> req);

    // R4: level mode holds no state; an idle-high pin leaves no request behind
    p_level_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEVEL && !wr_en) |=> (req == ~pin_s));

endmodule

// File: rtl/ext_irq_ctl.sv
module ext_irq_ctl
    import ext_irq_pkg::*;
#(
    parameter int NUM_SRC     = 2,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pin_n,
    input  logic [NUM_SRC-1:0] irq_ack,
    input  logic               ctl_we,
    input  logic [REG_W-1:0]   ctl_wdata,
    output logic [REG_W-1:0]   ctl_rdata,
    output logic [NUM_SRC-1:0] irq_req
);

    localparam int OWN_BITS = NUM_SRC * FIELD_W;

    logic [NUM_SRC-1:0] pin_s;
    logic [NUM_SRC-1:0] type_rd;
    logic [NUM_SRC-1:0] flag_rd;

    ext_irq_sync #(
        .WIDTH     (NUM_SRC),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_pin_n),
        .q_sync  (pin_s)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_src
            ext_irq_channel u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_s   (pin_s[i]),
                .wr_en   (ctl_we),
                .wr_type (ctl_wdata[i*FIELD_W + TYPE_OFS]),
                .wr_flag (ctl_wdata[i*FIELD_W + FLAG_OFS]),
                .ack     (irq_ack[i]),
                .req     (irq_req[i]),
                .type_rd (type_rd[i]),
                .flag_rd (flag_rd[i])
            );
        end
    endgenerate

    // Readback: fields this block owns, everything above reads zero
    always_comb begin
        ctl_rdata = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            ctl_rdata[k*FIELD_W + TYPE_OFS] = type_rd[k];
            ctl_rdata[k*FIELD_W + FLAG_OFS] = flag_rd[k];
        end
    end

    // R2: bits not owned here never read back as set
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[REG_W-1:OWN_BITS] == '0);

    // R2: a written type field is visible in the readback on the next clock
    p_type_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (type_rd[0] == $past(ctl_wdata[TYPE_OFS])));

endmodule

// File: tb/sim_ext_irq_ctl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctl;

    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_n = '1;
    logic [N-1:0] ack = '0;
    logic         we = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [N-1:0] req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_ctl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin_n (pin_n),
        .irq_ack   (ack),
        .ctl_we    (we),
        .ctl_wdata (wdata),
        .ctl_rdata (rdata),
        .irq_req   (req)
    );

    // Behavioural reference model
    logic [N-1:0] m_s1 = '1, m_s2 = '1, m_prev = '1, m_type = '0, m_flag = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_type <= '0; m_flag <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit nt;
                bit fall;
                nt   = we ? wdata[2*i] : m_type[i];
                fall = m_prev[i] && !m_s2[i];
                if (!nt)                   m_flag[i] <= 1'b0;
                else if (m_type[i] && fall) m_flag[i] <= 1'b1;
                else if (we)               m_flag[i] <= wdata[2*i+1];
                else if (ack[i])           m_flag[i] <= 1'b0;
                m_type[i] <= nt;
            end
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= pin_n;
        end
    end

    function automatic logic [N-1:0] exp_req();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = m_type[i] ? m_flag[i] : !m_s2[i];
        return r;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [7:0]   r = '0;
        logic [N-1:0] q = exp_req();
        for (int i = 0; i < N; i++) begin
            r[2*i]   = m_type[i];
            r[2*i+1] = q[i];
        end
        return r;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (req !== exp_req() || rdata !== exp_rd()) begin
                failures++;
                $display("FAIL model R3/R5/R7/R8: req=%b rd=%h expected req=%b rd=%h",
                         req, rdata, exp_req(), exp_rd());
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        we = 1'b1; wdata = d;
        tick();
        we = 1'b0; wdata = '0;
    endtask

    task automatic pulse_ack(logic [N-1:0] a);
        ack = a;
        tick();
        ack = '0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 req", {6'd0, req}, 8'h00);

        // R2: upper bits ignored, type bits land at positions 0 and 2
        wr(8'hF5);
        chk("R2 layout", rdata, 8'h05);

        // R5: falling edge latency
        pin_n = 2'b10;
        tick(2);
        chk("R5 not yet", {7'd0, req[0]}, 8'h00);
        tick();
        chk("R5 set", {7'd0, req[0]}, 8'h01);
        chk("R5 rdata", rdata, 8'h07);

        // R6: sticky after pin returns high
        pin_n = 2'b11;
        tick(4);
        chk("R6 sticky", {7'd0, req[0]}, 8'h01);

        // R7: acknowledge clears
        pulse_ack(2'b01);
        chk("R7 ack clears", {7'd0, req[0]}, 8'h00);

        // R9: edge and acknowledge on the same clock
        pin_n = 2'b10;
        tick(2);
        ack = 2'b01;
        tick();
        ack = '0;
        chk("R9 edge wins", {7'd0, req[0]}, 8'h01);
        pin_n = 2'b11;
        tick(3);

        // R8: software clear and set
        wr(8'h05);
        chk("R8 sw clear", {7'd0, req[0]}, 8'h00);
        wr(8'h0D);
        chk("R8 sw set", rdata, 8'h0D);
        wr(8'h05);
        chk("R8 sw clear1", {6'd0, req}, 8'h00);

        // R11: independence
        pin_n = 2'b01;
        tick(3);
        chk("R11 src1 only", {6'd0, req}, 8'h02);
        pulse_ack(2'b01);
        chk("R11 ack0 no effect on src1", {6'd0, req}, 8'h02);
        pin_n = 2'b11;
        pulse_ack(2'b10);
        chk("R11 ack1", {6'd0, req}, 8'h00);
        tick(3);

        // R3: level mode
        wr(8'h00);
        chk("R3 idle", {6'd0, req}, 8'h00);
        pin_n = 2'b10;
        tick();
        chk("R3 one stage", {7'd0, req[0]}, 8'h00);
        tick();
        chk("R3 follows", {7'd0, req[0]}, 8'h01);
        chk("R3 flag reads level", rdata, 8'h02);

        // R4: acknowledge latches nothing in level mode
        ack = 2'b01;
        tick(3);
        ack = '0;
        chk("R4 still low pin", {7'd0, req[0]}, 8'h01);
        pin_n = 2'b11;
        tick(2);
        chk("R4 drops", {7'd0, req[0]}, 8'h00);

        // R10: switching to level discards a pending flag
        wr(8'h01);
        pin_n = 2'b10;
        tick(3);
        chk("R10 pending", {7'd0, req[0]}, 8'h01);
        pin_n = 2'b11;
        tick(2);
        wr(8'h00);
        chk("R10 level drop", {7'd0, req[0]}, 8'h00);
        wr(8'h01);
        chk("R10 back to edge clear", rdata, 8'h01);
        tick(2);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule